// File: doc/BRIEF.md
# Legacy Interrupt Line Aggregator

This block merges the level-sensitive legacy interrupt pins of a group of PCI device slots onto four shared bus interrupt lines. Every slot presents four pins. The block keeps the last level it sampled on each pin. When a pin rises or falls, the block looks up which bus line that pin is wired to and adds one to, or takes one from, that line's counter. The pin-to-line wiring rotates with the slot's device number. An optional second rotation models the remapping done when the slots sit behind a bridge.

A bus line is asserted while its counter is nonzero. The result is equivalent to a wired OR of the sources. Because the block counts sources and responds only to level changes, clearing a slot's sources always leaves the line state correct.

The counters are also brought out on a flat debug vector. This lets integration logic and tests observe how many sources hold each line.

Top module: `intx_aggregator`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising clock edge, every held pin level and every line counter is cleared, so all of `cnt_dbg` and `irq_line` read zero after that edge, whatever the pin inputs are.
- R2: A pin sampled high after being held low adds one to the counter of its bus line, visible after the sampling edge. Pin p of slot s is bit `pin_lvl[s*4+p]`, and that slot's device number is FIRST_DEV+s. With BRIDGE_EN=0 the pin maps to line (p + FIRST_DEV + s) mod 4. Line l's counter is `cnt_dbg[l*CW +: CW]`, where CW = clog2(NUM_SLOTS*4+1).
- R3: A pin sampled low after being held high subtracts one from the counter of the same bus line that R2 gives.
- R4: A pin sampled at the same level it already holds leaves every counter and every line unchanged.
- R5: `irq_line[l]` is high exactly when line l's counter is nonzero.
- R6: Rises and falls on any number of pins at the same edge are all summed into the counters at that edge.
- R7: With BRIDGE_EN=1, the line given by R2 is rotated again by the bridge's own device number: the final line is (line + BRIDGE_DEV) mod 4.
- R8: No counter ever exceeds NUM_SLOTS, and no counter ever wraps below zero.
- R9: After reset is released, any pins that are already high count as fresh rises on the first edge that samples them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | NUM_SLOTS*4 | Pin levels; bit s*4+p is pin p of slot s |
| irq_line | output | 4 | Bus interrupt lines, active high |
| cnt_dbg | output | 4*CW | Per-line source counters; line l is at bits l*CW +: CW |

## Verification
The bench builds two copies of the block, each with three slots whose device numbers start at 1.

- One copy routes the pins directly.
- The other copy adds a bridge rotation of 2.

Twelve pins give 4096 input patterns, so the bench sweeps all of them, both in counting order and in a scrambled order that flips many pins at once. Every counter value from zero to the per-line maximum is reached on every line, in both routing variants. The bench also covers held levels and a reset applied while all pins are high.

// File: rtl/intx_pkg.sv
package intx_pkg;

  localparam int PINS_PER_SLOT = 4;
  localparam int BUS_LINES     = 4;

  // Rotate a pin number by a device number onto one of the four bus lines.
  function automatic logic [1:0] swizzle(input int dev, input int pin);
    int sum;
    sum = (dev + pin) % BUS_LINES;
    return sum[1:0];
  endfunction

  // Full route: slot swizzle, then optionally the bridge's own swizzle.
  function automatic logic [1:0] route_line(input int dev, input int pin,
                                            input bit brg_en, input int brg_dev);
    logic [1:0] first;
    first = swizzle(dev, pin);
    if (brg_en) return swizzle(brg_dev, int'(first));
    return first;
  endfunction

  // Counter width able to hold every source of the block.
  function automatic int count_width(input int slots);
    return $clog2(slots * PINS_PER_SLOT + 1);
  endfunction

endpackage

// File: rtl/intx_level_tracker.sv
module intx_level_tracker #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_in,
  output logic [WIDTH-1:0] lvl_q,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_in;
  end

  // Events only when a sampled level differs from the held one.
  assign rise = rst ? '0 : (lvl_in & ~lvl_q);
  assign fall = rst ? '0 : (~lvl_in & lvl_q);

endmodule

// File: rtl/intx_route_sum.sv
module intx_route_sum
  import intx_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int FIRST_DEV  = 0,
  parameter bit BRIDGE_EN  = 1'b0,
  parameter int BRIDGE_DEV = 0,
  parameter int CW         = 6
) (
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] rise,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] fall,
  output logic [BUS_LINES*CW-1:0]            up_cnt,
  output logic [BUS_LINES*CW-1:0]            dn_cnt
);

  logic [CW-1:0] up_a [BUS_LINES];
  logic [CW-1:0] dn_a [BUS_LINES];

  always_comb begin
    logic [1:0] ln;
    ln = '0;
    for (int l = 0; l < BUS_LINES; l++) begin
      up_a[l] = '0;
      dn_a[l] = '0;
    end
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < PINS_PER_SLOT; p++) begin
        ln = route_line(FIRST_DEV + s, p, BRIDGE_EN, BRIDGE_DEV);
        if (rise[s*PINS_PER_SLOT + p]) up_a[ln] = up_a[ln] + CW'(1);
        if (fall[s*PINS_PER_SLOT + p]) dn_a[ln] = dn_a[ln] + CW'(1);
      end
    end
  end

  for (genvar l = 0; l < BUS_LINES; l++) begin : g_pack
    assign up_cnt[l*CW +: CW] = up_a[l];
    assign dn_cnt[l*CW +: CW] = dn_a[l];
  end

endmodule

// File: rtl/intx_line_counter.sv
module intx_line_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] up,
  input  logic [CW-1:0] dn,
  output logic [CW-1:0] count_q,
  output logic          active
);

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + up - dn;
  end

  assign active = |count_q;

endmodule

// File: rtl/intx_aggregator.sv
module intx_aggregator
  import intx_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int FIRST_DEV  = 0,
  parameter bit BRIDGE_EN  = 1'b0,
  parameter int BRIDGE_DEV = 0,
  localparam int CW        = count_width(NUM_SLOTS),
  localparam int NPINS     = NUM_SLOTS * PINS_PER_SLOT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPINS-1:0]        pin_lvl,
  output logic [BUS_LINES-1:0]    irq_line,
  output logic [BUS_LINES*CW-1:0] cnt_dbg
);

  // Named internal events, visible to the bound checker.
  logic [NPINS-1:0]        held_lvl;
  logic [NPINS-1:0]        rise_evt;
  logic [NPINS-1:0]        fall_evt;
  logic [BUS_LINES*CW-1:0] up_cnt;
  logic [BUS_LINES*CW-1:0] dn_cnt;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    intx_level_tracker #(.WIDTH(PINS_PER_SLOT)) u_trk (
      .clk    (clk),
      .rst    (rst),
      .lvl_in (pin_lvl [s*PINS_PER_SLOT +: PINS_PER_SLOT]),
      .lvl_q  (held_lvl[s*PINS_PER_SLOT +: PINS_PER_SLOT]),
      .rise   (rise_evt[s*PINS_PER_SLOT +: PINS_PER_SLOT]),
      .fall   (fall_evt[s*PINS_PER_SLOT +: PINS_PER_SLOT])
    );
  end

  intx_route_sum #(
    .NUM_SLOTS (NUM_SLOTS),
    .FIRST_DEV (FIRST_DEV),
    .BRIDGE_EN (BRIDGE_EN),
    .BRIDGE_DEV(BRIDGE_DEV),
    .CW        (CW)
  ) u_route (
    .rise   (rise_evt),
    .fall   (fall_evt),
    .up_cnt (up_cnt),
    .dn_cnt (dn_cnt)
  );

  for (genvar l = 0; l < BUS_LINES; l++) begin : g_line
    intx_line_counter #(.CW(CW)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .up      (up_cnt[l*CW +: CW]),
      .dn      (dn_cnt[l*CW +: CW]),
      .count_q (cnt_dbg[l*CW +: CW]),
      .active  (irq_line[l])
    );
  end

endmodule

// File: rtl/intx_aggregator_chk.sv
module intx_aggregator_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int CW        = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_SLOTS*4-1:0]  pin_lvl,
  input logic [NUM_SLOTS*4-1:0]  held_lvl,
  input logic [4*CW-1:0]         cnt_dbg
);

  function automatic int total(input logic [4*CW-1:0] v);
    int t;
    t = 0;
    for (int l = 0; l < 4; l++) t += int'(v[l*CW +: CW]);
    return t;
  endfunction

  // R1: the edge after reset leaves every counter at zero.
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt_dbg == '0));

  // R2/R3: counters in total equal the number of held high sources.
  assert_total_matches_R2: assert property (@(posedge clk) disable iff (rst)
    total(cnt_dbg) == $countones(held_lvl));

  // R4: unchanged inputs leave the counters unchanged.
  assert_hold_no_effect_R4: assert property (@(posedge clk) disable iff (rst)
    ($stable(pin_lvl) && !$past(rst)) |=> $stable(cnt_dbg));

  // R8: per-line bound, which also catches a wrap below zero.
  for (genvar l = 0; l < 4; l++) begin : g_bound
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
      int'(cnt_dbg[l*CW +: CW]) <= NUM_SLOTS);
  end

endmodule

bind intx_aggregator intx_aggregator_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .CW       (CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pin_lvl  (pin_lvl),
  .held_lvl (held_lvl),
  .cnt_dbg  (cnt_dbg)
);

// File: tb/test_intx_aggregator.sv
`timescale 1ns/1ps
module test_intx_aggregator;

  localparam int NS  = 3;
  localparam int NP  = NS * 4;
  localparam int CWB = 4;   // clog2(3*4+1)

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP-1:0]   pins = '0;
  logic [3:0]      irq0, irq1;
  logic [4*CWB-1:0] cnt0, cnt1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  intx_aggregator #(.NUM_SLOTS(NS), .FIRST_DEV(1), .BRIDGE_EN(1'b0), .BRIDGE_DEV(0))
    i_intx_aggregator (.clk(clk), .rst(rst), .pin_lvl(pins), .irq_line(irq0), .cnt_dbg(cnt0));

  intx_aggregator #(.NUM_SLOTS(NS), .FIRST_DEV(1), .BRIDGE_EN(1'b1), .BRIDGE_DEV(2))
    i_intx_aggregator_brg (.clk(clk), .rst(rst), .pin_lvl(pins), .irq_line(irq1), .cnt_dbg(cnt1));

  // Expected counters: each high pin adds one to line (pin + dev + rot) & 3.
  function automatic logic [4*CWB-1:0] model_cnt(input logic [NP-1:0] pat, input int rot);
    logic [4*CWB-1:0] r;
    int c [4];
    for (int l = 0; l < 4; l++) c[l] = 0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++)
        if (pat[s*4+p]) c[(p + 1 + s + rot) & 3] += 1;
    for (int l = 0; l < 4; l++) r[l*CWB +: CWB] = CWB'(c[l]);
    return r;
  endfunction

  function automatic logic [3:0] model_irq(input logic [4*CWB-1:0] c);
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = (c[l*CWB +: CWB] != 0);
    return r;
  endfunction

  task automatic check_both(input string tag, input logic [NP-1:0] pat);
    logic [4*CWB-1:0] e0, e1;
    e0 = model_cnt(pat, 0);
    e1 = model_cnt(pat, 2);
    checks++;
    if (cnt0 !== e0 || irq0 !== model_irq(e0)) begin
      fails++;
      $display("FAIL %s (R5, direct) pat=%h: cnt=%h irq=%b expected cnt=%h irq=%b",
               tag, pat, cnt0, irq0, e0, model_irq(e0));
    end
    checks++;
    if (cnt1 !== e1 || irq1 !== model_irq(e1)) begin
      fails++;
      $display("FAIL %s (R7, bridge) pat=%h: cnt=%h irq=%b expected cnt=%h irq=%b",
               tag, pat, cnt1, irq1, e1, model_irq(e1));
    end
  endtask

  task automatic apply(input logic [NP-1:0] pat);
    @(negedge clk);
    pins = pat;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state with pins low.
    repeat (3) @(negedge clk);
    check_both("R1 reset state", '0);
    rst = 1'b0;

    // R2 R3 R6: ascending sweep, carries flip several pins at once.
    for (int v = 0; v < 4096; v++) begin
      apply(NP'(v));
      check_both("R2/R3/R6 ascending sweep", NP'(v));
    end

    // R6 R8: scrambled order, many simultaneous rises and falls.
    for (int v = 0; v < 4096; v++) begin
      logic [NP-1:0] pat;
      pat = NP'((v * 2731) & 12'hfff);
      apply(pat);
      check_both("R6/R8 scrambled sweep", pat);
    end

    // R4: held levels leave everything unchanged.
    for (int k = 0; k < 6; k++) begin
      logic [NP-1:0] pat;
      pat = NP'((k * 1453 + 77) & 12'hfff);
      apply(pat);
      repeat (3) @(negedge clk);
      check_both("R4 held level", pat);
    end

    // R1 R9: reset with every pin high, then release.
    apply('1);
    check_both("R8 all sources", '1);
    rst = 1'b1;
    @(negedge clk);
    check_both("R1 reset ignores high pins", '0);
    rst = 1'b0;
    @(negedge clk);
    check_both("R9 high pins recount after reset", '1);

    // R3: drop everything back to zero.
    apply('0);
    check_both("R3 all fall", '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule